// File: doc/BRIEF.md
# Tangent-Line Point Doubler over a Quadratic Extension Field

This block doubles a point S = (X1, Y1, Z1) held in projective coordinates on the sextic twist y² = x³ + (1 − i) of the base curve y² = x³ + 2. It works over Fp2 = Fp[i] / (i² + 1). In the same pass it produces the three non-zero coefficients of the tangent line at S, evaluated at a base-field point P. The line takes the form t0 + t1·γ + t3·γ³. Updating the pairing accumulator with that line is left to the surrounding engine.

The caller supplies the point, the coordinate yP and the precomputed value xP' = −3·xP, and then pulses `start`. A fixed 30-step program runs on one shared Fp2 multiply/square unit, which also performs Fp-by-Fp2 scaling, and on one Fp2 add/subtract unit. One step is written back per clock. `done` then pulses, and the six results remain on the outputs until the next accepted start. The modulus p is a parameter with p ≡ 3 (mod 4). The default is a small prime, so that exhaustive checks stay cheap.

Top module: `tan_dbl_core`

## Requirements
- R1: Each Fp2 port carries a + b·i with the real part a in bits [W-1:0] and the imaginary part b in bits [2W-1:W], where i² = −1. Every input and output part lies in [0, p). yP and xP' are plain Fp values of W bits.
- R2: A rising edge that samples `start` high while idle begins a run. `done_o` is high for exactly one cycle, which begins at the 30th rising edge after that edge. It is low at all other times.
- R3: x3_o = 2·X1·Y1·(Y1² − 9(1 − i)Z1²) mod p.
- R4: y3_o = (Y1² + 9(1 − i)Z1²)² − 108(1 − i)²Z1⁴ mod p.
- R5: z3_o = 8·Y1³·Z1 mod p.
- R6: l0_o = yP·2·Y1·Z1, l1_o = xP'·X1², and l3_o = Y1² − 3(1 − i)Z1², all taken mod p.
- R7: A `start` that arrives during a run has no effect. Neither the result of that run nor the timing of its `done` changes.
- R8: While idle with `start` low, all six result outputs hold their values.
- R9: After reset, `done_o` is low and all six result outputs are zero.
- R10: Operands at the top of the field (every part equal to p − 1) and all-zero operands give correctly reduced results.
- R11: For an affine point (x, y) on y² = x³ + (1 − i) with y ≠ 0, given in any scaling (x·z, y·z, z) with z ≠ 0, the ratios x3/z3 and y3/z3 equal the affine tangent doubling: λ = 3x²/(2y), x' = λ² − 2x, y' = λ(x − x') − y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Run request, sampled when idle |
| x1_i | input | 2W | Point X coordinate in Fp2 |
| y1_i | input | 2W | Point Y coordinate in Fp2 |
| z1_i | input | 2W | Point Z coordinate in Fp2 |
| yp_i | input | W | Base point y coordinate in Fp |
| xpn_i | input | W | Base point −3·x in Fp |
| x3_o | output | 2W | Doubled point X |
| y3_o | output | 2W | Doubled point Y |
| z3_o | output | 2W | Doubled point Z |
| l0_o | output | 2W | Line coefficient of γ⁰ |
| l1_o | output | 2W | Line coefficient of γ¹ |
| l3_o | output | 2W | Line coefficient of γ³ |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest property to reach from the ports is geometric: the projective outputs must describe the true double of a point on the twist. A random coordinate triple almost never lies on that curve. The bench therefore searches the small field exhaustively for an x whose right-hand side x³ + (1 − i) is a square in Fp2, finds its root y, and scales the point by a non-unit z before feeding it in. It then compares the ratios of the outputs against affine tangent doubling, computed with Fermat inversion. A second hard case is a stray `start` in the middle of a run. The bench raises it together with inverted operands and relies on its per-cycle model of `done` and on the closed-form results to catch any disturbance.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

    localparam int NUM_STEPS = 30;
    localparam int NREG      = 14;

    typedef enum logic [3:0] {
        RX1, RY1, RZ1, RYP, RXP,
        RT1, RT2, RT3,
        RX3, RY3, RZ3,
        RL0, RL1, RL3
    } reg_e;

    typedef enum logic [2:0] {
        OP_ADD, OP_SUB, OP_MULI, OP_MUL, OP_SCL
    } op_e;

    typedef struct packed {
        op_e  op;
        reg_e dst;
        reg_e src_a;
        reg_e src_b;
    } step_t;

endpackage

// File: rtl/tdl_rom.sv
module tdl_rom
    import tdl_pkg::*;
(
    input  logic [4:0] idx_i,
    output step_t      step_o
);
    // Squarings are multiplications with both sources equal; doublings are adds.
    always_comb begin
        case (idx_i)
            5'd0:  step_o = '{OP_MUL,  RT1, RX1, RX1};
            5'd1:  step_o = '{OP_MUL,  RT2, RY1, RY1};
            5'd2:  step_o = '{OP_MUL,  RT3, RZ1, RZ1};
            5'd3:  step_o = '{OP_ADD,  RX3, RX1, RY1};
            5'd4:  step_o = '{OP_MUL,  RX3, RX3, RX3};
            5'd5:  step_o = '{OP_SUB,  RX3, RX3, RT1};
            5'd6:  step_o = '{OP_SUB,  RX3, RX3, RT2};
            5'd7:  step_o = '{OP_ADD,  RL1, RY1, RZ1};
            5'd8:  step_o = '{OP_MUL,  RL1, RL1, RL1};
            5'd9:  step_o = '{OP_SUB,  RL1, RL1, RT2};
            5'd10: step_o = '{OP_SUB,  RL1, RL1, RT3};
            5'd11: step_o = '{OP_MULI, RL0, RT3, RT3};
            5'd12: step_o = '{OP_ADD,  RL3, RL0, RL0};
            5'd13: step_o = '{OP_ADD,  RL0, RL0, RL3};
            5'd14: step_o = '{OP_ADD,  RY3, RL0, RL0};
            5'd15: step_o = '{OP_ADD,  RL3, RL0, RY3};
            5'd16: step_o = '{OP_SUB,  RZ3, RT2, RL3};
            5'd17: step_o = '{OP_MUL,  RX3, RX3, RZ3};
            5'd18: step_o = '{OP_ADD,  RL3, RT2, RL3};
            5'd19: step_o = '{OP_MUL,  RL3, RL3, RL3};
            5'd20: step_o = '{OP_MUL,  RY3, RY3, RY3};
            5'd21: step_o = '{OP_SUB,  RL3, RL3, RY3};
            5'd22: step_o = '{OP_ADD,  RY3, RY3, RY3};
            5'd23: step_o = '{OP_SUB,  RY3, RL3, RY3};
            5'd24: step_o = '{OP_MUL,  RZ3, RT2, RL1};
            5'd25: step_o = '{OP_ADD,  RZ3, RZ3, RZ3};
            5'd26: step_o = '{OP_ADD,  RZ3, RZ3, RZ3};
            5'd27: step_o = '{OP_SUB,  RL3, RT2, RL0};
            5'd28: step_o = '{OP_SCL,  RL0, RYP, RL1};
            5'd29: step_o = '{OP_SCL,  RL1, RXP, RT1};
            default: step_o = '{OP_ADD, RT1, RT1, RT1};
        endcase
    end
endmodule

// File: rtl/fp2_lin.sv
module fp2_lin
    import tdl_pkg::*;
#(
    parameter int W = 8,
    parameter int P = 251
) (
    input  op_e            op_i,
    input  logic [2*W-1:0] a_i,
    input  logic [2*W-1:0] b_i,
    output logic [2*W-1:0] r_o
);
    localparam logic [W:0] PW = (W+1)'(P);

    function automatic logic [W-1:0] m_add(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= PW) s = s - PW;
        return s[W-1:0];
    endfunction

    function automatic logic [W-1:0] m_sub(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] s;
        if (a >= b) s = {1'b0, a} - {1'b0, b};
        else        s = {1'b0, a} + PW - {1'b0, b};
        return s[W-1:0];
    endfunction

    logic [W-1:0] sum_l [2];
    logic [W-1:0] dif_l [2];

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign sum_l[g] = m_add(a_i[g*W +: W], b_i[g*W +: W]);
        assign dif_l[g] = m_sub(a_i[g*W +: W], b_i[g*W +: W]);
    end

    logic [W-1:0] twre_w, twim_w;
    // (1 - i)(a + b i) = (a + b) + (b - a) i
    assign twre_w = m_add(a_i[W-1:0], a_i[2*W-1:W]);
    assign twim_w = m_sub(a_i[2*W-1:W], a_i[W-1:0]);

    always_comb begin
        case (op_i)
            OP_SUB:  r_o = {dif_l[1], dif_l[0]};
            OP_MULI: r_o = {twim_w, twre_w};
            default: r_o = {sum_l[1], sum_l[0]};
        endcase
    end
endmodule

// File: rtl/fp2_mul.sv
module fp2_mul #(
    parameter int W = 8,
    parameter int P = 251
) (
    input  logic           scl_i,
    input  logic [2*W-1:0] a_i,
    input  logic [2*W-1:0] b_i,
    output logic [2*W-1:0] r_o
);
    localparam logic [W:0]     PW = (W+1)'(P);
    localparam logic [2*W-1:0] PM = (2*W)'(P);

    function automatic logic [W-1:0] m_add(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= PW) s = s - PW;
        return s[W-1:0];
    endfunction

    function automatic logic [W-1:0] m_sub(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] s;
        if (a >= b) s = {1'b0, a} - {1'b0, b};
        else        s = {1'b0, a} + PW - {1'b0, b};
        return s[W-1:0];
    endfunction

    function automatic logic [W-1:0] m_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [2*W-1:0] pr;
        pr = (2*W)'(a) * (2*W)'(b);
        pr = pr % PM;
        return pr[W-1:0];
    endfunction

    logic [W-1:0] a_re, a_im, b_re, b_im;
    assign a_re = a_i[W-1:0];
    assign a_im = a_i[2*W-1:W];
    assign b_re = b_i[W-1:0];
    assign b_im = b_i[2*W-1:W];

    logic [W-1:0] rr_w, ii_w, ri_w, ir_w;
    assign rr_w = m_mul(a_re, b_re);
    assign ii_w = m_mul(a_im, b_im);
    assign ri_w = m_mul(a_re, b_im);
    assign ir_w = m_mul(a_im, b_re);

    // Scaling treats a_i as an Fp value and reuses two of the four products.
    always_comb begin
        if (scl_i) r_o = {ri_w, rr_w};
        else       r_o = {m_add(ri_w, ir_w), m_sub(rr_w, ii_w)};
    end
endmodule

// File: rtl/tan_dbl_core.sv
module tan_dbl_core
    import tdl_pkg::*;
#(
    parameter int W = 8,
    parameter int P = 251
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [2*W-1:0] x1_i,
    input  logic [2*W-1:0] y1_i,
    input  logic [2*W-1:0] z1_i,
    input  logic [W-1:0]   yp_i,
    input  logic [W-1:0]   xpn_i,
    output logic [2*W-1:0] x3_o,
    output logic [2*W-1:0] y3_o,
    output logic [2*W-1:0] z3_o,
    output logic [2*W-1:0] l0_o,
    output logic [2*W-1:0] l1_o,
    output logic [2*W-1:0] l3_o,
    output logic           done_o
);
    localparam int         FW        = 2 * W;
    localparam logic [4:0] LAST_STEP = 5'(NUM_STEPS - 1);
    localparam logic [W:0] PW        = (W+1)'(P);

    typedef struct packed {
        logic                     busy;
        logic                     done;
        logic [4:0]               step;
        logic [NREG-1:0][FW-1:0]  rf;
    } st_t;

    st_t st_d, st_q;

    step_t          cur_w;
    logic [FW-1:0]  opa_w, opb_w, lin_w, mul_w, res_w;
    logic           use_mul_w;

    tdl_rom u_rom (
        .idx_i  (st_q.step),
        .step_o (cur_w)
    );

    assign opa_w     = st_q.rf[cur_w.src_a];
    assign opb_w     = st_q.rf[cur_w.src_b];
    assign use_mul_w = (cur_w.op == OP_MUL) || (cur_w.op == OP_SCL);

    fp2_lin #(.W(W), .P(P)) u_lin (
        .op_i (cur_w.op),
        .a_i  (opa_w),
        .b_i  (opb_w),
        .r_o  (lin_w)
    );

    fp2_mul #(.W(W), .P(P)) u_mul (
        .scl_i (cur_w.op == OP_SCL),
        .a_i   (opa_w),
        .b_i   (opb_w),
        .r_o   (mul_w)
    );

    assign res_w = use_mul_w ? mul_w : lin_w;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy     = 1'b1;
                st_d.step     = 5'd0;
                st_d.rf[RX1]  = x1_i;
                st_d.rf[RY1]  = y1_i;
                st_d.rf[RZ1]  = z1_i;
                st_d.rf[RYP]  = {{W{1'b0}}, yp_i};
                st_d.rf[RXP]  = {{W{1'b0}}, xpn_i};
            end
        end else begin
            st_d.rf[cur_w.dst] = res_w;
            if (st_q.step == LAST_STEP) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.step = st_q.step + 5'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign x3_o   = st_q.rf[RX3];
    assign y3_o   = st_q.rf[RY3];
    assign z3_o   = st_q.rf[RZ3];
    assign l0_o   = st_q.rf[RL0];
    assign l1_o   = st_q.rf[RL1];
    assign l3_o   = st_q.rf[RL3];
    assign done_o = st_q.done;

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R2
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> ($past(st_q.busy) && $past(st_q.step) == LAST_STEP));

    // R7
    step_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.step != LAST_STEP) |=>
        (st_q.busy && st_q.step == $past(st_q.step) + 5'd1));

    // R10
    reduced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> ({1'b0, res_w[W-1:0]} < PW && {1'b0, res_w[FW-1:W]} < PW));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !start_i) |=>
        ($stable(x3_o) && $stable(y3_o) && $stable(z3_o) &&
         $stable(l0_o) && $stable(l1_o) && $stable(l3_o)));

endmodule

// File: tb/tan_dbl_core_tb_top.sv
module tan_dbl_core_tb_top;
    localparam int W  = 8;
    localparam int P  = 251;
    localparam int FW = 2 * W;

    typedef struct { int re; int im; } f2_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [FW-1:0] x1 = '0, y1 = '0, z1 = '0;
    logic [W-1:0]  yp = '0, xpn = '0;
    logic [FW-1:0] x3, y3, z3, l0, l1, l3;
    logic done;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    tan_dbl_core #(.W(W), .P(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .x1_i(x1), .y1_i(y1), .z1_i(z1), .yp_i(yp), .xpn_i(xpn),
        .x3_o(x3), .y3_o(y3), .z3_o(z3), .l0_o(l0), .l1_o(l1), .l3_o(l3),
        .done_o(done)
    );

    // ---------------- field arithmetic of the reference ----------------
    function automatic int md(int a);
        return ((a % P) + P) % P;
    endfunction
    function automatic f2_t mk(int r, int i);
        f2_t v; v.re = md(r); v.im = md(i); return v;
    endfunction
    function automatic f2_t fadd(f2_t a, f2_t b);
        return mk(a.re + b.re, a.im + b.im);
    endfunction
    function automatic f2_t fsub(f2_t a, f2_t b);
        return mk(a.re - b.re, a.im - b.im);
    endfunction
    function automatic f2_t fmul(f2_t a, f2_t b);
        return mk(a.re * b.re - a.im * b.im, a.re * b.im + a.im * b.re);
    endfunction
    function automatic f2_t fk(int k, f2_t a);
        return mk(k * a.re, k * a.im);
    endfunction
    function automatic int fpow(int b, int e);
        int r = 1;
        for (int j = 0; j < e; j++) r = md(r * b);
        return r;
    endfunction
    function automatic f2_t finv(f2_t a);
        int n = md(a.re * a.re + a.im * a.im);
        int ni = fpow(n, P - 2);
        return mk(a.re * ni, -a.im * ni);
    endfunction
    function automatic logic [FW-1:0] pk(f2_t v);
        return {W'(v.im), W'(v.re)};
    endfunction
    function automatic f2_t upk(logic [FW-1:0] v);
        return mk(int'(v[W-1:0]), int'(v[FW-1:W]));
    endfunction

    task automatic chk(string tag, logic [FW-1:0] act, f2_t exp);
        n_chk++;
        if (act !== pk(exp)) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, pk(exp));
        end
    endtask

    // ---------------- cycle model of the completion pulse ----------------
    logic m_busy = 1'b0, m_done = 1'b0;
    int   m_cnt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_done = 1'b0; m_cnt = 0;
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == 30) begin m_busy = 1'b0; m_done = 1'b1; end
            end else if (start) begin
                m_busy = 1'b1; m_cnt = 0;
            end
        end
    end

    // R2 / R7: done compared with the model on every cycle
    always @(negedge clk) begin
        if (rst_n) begin
            n_chk++;
            if (done !== m_done) begin
                n_fail++;
                $display("FAIL R2/R7 done actual=%b expected=%b", done, m_done);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic run(f2_t x, f2_t y, f2_t z, int ypv, int xpv, int intrude_at);
        bit seen = 0;
        @(negedge clk);
        x1 = pk(x); y1 = pk(y); z1 = pk(z); yp = W'(ypv); xpn = W'(xpv);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 45; c++) begin
            @(negedge clk);
            if (done) begin seen = 1; break; end
            start = (c == intrude_at);
            if (c == intrude_at) begin x1 = ~x1; y1 = ~y1; z1 = ~z1; end
        end
        start = 1'b0;
        if (!seen) begin
            n_chk++; n_fail++;
            $display("FAIL R2 done actual=0 expected=1 within 31 cycles");
        end
    endtask

    task automatic check_closed(string grp, f2_t x, f2_t y, f2_t z, int ypv, int xpv);
        f2_t cz, y2, ypf, xpf;
        cz  = fmul(mk(1, -1), fmul(z, z));
        y2  = fmul(y, y);
        ypf = mk(ypv, 0);
        xpf = mk(xpv, 0);
        chk({grp, " R3 x3"}, x3, fmul(fk(2, fmul(x, y)), fsub(y2, fk(9, cz))));
        chk({grp, " R4 y3"}, y3, fsub(fmul(fadd(y2, fk(9, cz)), fadd(y2, fk(9, cz))),
                                      fk(108, fmul(cz, cz))));
        chk({grp, " R5 z3"}, z3, fk(8, fmul(fmul(y2, y), z)));
        chk({grp, " R6 l0"}, l0, fmul(ypf, fk(2, fmul(y, z))));
        chk({grp, " R6 l1"}, l1, fmul(xpf, fmul(x, x)));
        chk({grp, " R6 l3"}, l3, fsub(y2, fk(3, cz)));
    endtask

    initial begin
        f2_t ax, ay, zs;
        bit  found;
        int  seed;
        logic [FW-1:0] hx3, hy3, hz3, hl0, hl1, hl3;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        chk("R9 x3", x3, mk(0, 0)); chk("R9 y3", y3, mk(0, 0));
        chk("R9 z3", z3, mk(0, 0)); chk("R9 l0", l0, mk(0, 0));
        chk("R9 l1", l1, mk(0, 0)); chk("R9 l3", l3, mk(0, 0));
        n_chk++;
        if (done !== 1'b0) begin n_fail++; $display("FAIL R9 done actual=%b expected=0", done); end

        // R1 packing with a unit point
        run(mk(1, 0), mk(1, 0), mk(1, 0), 1, 1, -1);
        check_closed("R1 unit", mk(1, 0), mk(1, 0), mk(1, 0), 1, 1);

        // R10: top of field, and zeros
        run(mk(P-1, P-1), mk(P-1, P-1), mk(P-1, P-1), P-1, P-1, -1);
        check_closed("R10 max", mk(P-1, P-1), mk(P-1, P-1), mk(P-1, P-1), P-1, P-1);
        run(mk(0, 0), mk(0, 0), mk(0, 0), 0, 0, -1);
        check_closed("R10 zero", mk(0, 0), mk(0, 0), mk(0, 0), 0, 0);

        // R3..R6 over pseudo-random operands
        seed = 12345;
        for (int k = 0; k < 8; k++) begin
            f2_t a, b, c;
            int q, r;
            seed = md(seed * 37 + 101); a = mk(seed, seed * 3 + 7);
            seed = md(seed * 53 + 17);  b = mk(seed, seed * 5 + 2);
            seed = md(seed * 41 + 29);  c = mk(seed, seed * 7 + 11);
            q = md(seed * 13 + k); r = md(seed * 19 + 3 * k);
            run(a, b, c, q, r, -1);
            check_closed("R3-6 mix", a, b, c, q, r);
        end

        // R7: stray start in mid-run with inverted operands
        run(mk(17, 40), mk(99, 3), mk(5, 222), 77, 150, 12);
        check_closed("R7 intrude", mk(17, 40), mk(99, 3), mk(5, 222), 77, 150);

        // R8: hold while idle with changing inputs
        hx3 = x3; hy3 = y3; hz3 = z3; hl0 = l0; hl1 = l1; hl3 = l3;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            x1 = x1 + 16'h0101; yp = yp + 8'd3;
        end
        chk("R8 x3", x3, upk(hx3)); chk("R8 y3", y3, upk(hy3));
        chk("R8 z3", z3, upk(hz3)); chk("R8 l0", l0, upk(hl0));
        chk("R8 l1", l1, upk(hl1)); chk("R8 l3", l3, upk(hl3));

        // R11: find points on y^2 = x^3 + (1 - i) and compare with affine doubling
        for (int xr = 2; xr < 12; xr++) begin
            f2_t rhs, lam, xe, ye, izz;
            found = 0;
            ax  = mk(xr, 5);
            rhs = fadd(fmul(fmul(ax, ax), ax), mk(1, -1));
            for (int yr = 0; yr < P && !found; yr++)
                for (int yi = 0; yi < P && !found; yi++) begin
                    f2_t cy = mk(yr, yi);
                    if ((yr != 0 || yi != 0) && fmul(cy, cy) == rhs) begin
                        ay = cy; found = 1;
                    end
                end
            if (found) begin
                zs = mk(3 + xr, 7);
                run(fmul(ax, zs), fmul(ay, zs), zs, 9, 4, -1);
                lam = fmul(fk(3, fmul(ax, ax)), finv(fk(2, ay)));
                xe  = fsub(fmul(lam, lam), fk(2, ax));
                ye  = fsub(fmul(lam, fsub(ax, xe)), ay);
                izz = finv(upk(z3));
                chk("R11 affine x", pk(fmul(upk(x3), izz)), xe);
                chk("R11 affine y", pk(fmul(upk(y3), izz)), ye);
            end
        end

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule